// File: doc/BRIEF.md
# ISA Bus Clock Generator with Selectable Ratio

This block derives the ISA bus clock from one of two timing sources, chosen by a 3-bit speed code. Code 0 runs the bus at half of the 14.318 MHz reference (about 7.159 MHz). Codes 1 to 7 divide the fast bus clock, PCLK2, by 1.5, 2, 2.5, 3, 4, 5 or 6. Each source reaches the block as a one-cycle tick enable in a single fast system clock domain. The reference tick fires once per reference period. The divider tick fires twice per PCLK2 period. Counting double-rate ticks lets the half-integer ratios use whole tick counts, so the block needs no second clock edge.

An output period lasts 2 reference ticks in code 0. In the other codes it lasts 3, 4, 5, 6, 8, 10 or 12 divider ticks. The high phase takes the larger half of the ticks. The speed code comes from an 8-bit configuration register value, and only its three low bits are used. A new code is adopted only when the current output period ends, so changing the code never cuts a phase short. A one-cycle strobe marks every rising edge of the ISA clock. Logic clocked on the system clock can use it as a clock enable.

Top module: `isa_clk_gen`

## Requirements
- R1: Only bits [2:0] of `speed_reg` choose the ratio. Bits [7:3] have no effect on either output.
- R2: With code 0 active, one output period is 2 `ref_tick` pulses: 1 tick high, then 1 tick low. `dbl_tick` has no effect in this code.
- R3: With code c in 1..7 active, one output period is 3, 4, 5, 6, 8, 10 or 12 `dbl_tick` pulses (c = 1..7). `ref_tick` has no effect in these codes.
- R4: The high phase lasts ceil(P/2) ticks of the active source and the low phase lasts floor(P/2), where P is the period in ticks. For example, code 1 gives 2 high and 1 low, and code 7 gives 6 high and 6 low.
- R5: During reset and just after it, `isa_clk` and `isa_rise` are 0 and code 0 is active. The first `ref_tick` after reset raises `isa_clk`.
- R6: `speed_reg` is sampled only on the tick that ends a period, and the next period uses that value. A change made in the middle of a period leaves the rest of that period unchanged.
- R7: `isa_rise` is 1 for exactly the system clock cycle in which `isa_clk` has just gone from 0 to 1, and is 0 in every other cycle.
- R8: `isa_clk` changes only in the cycle after a tick of the active source is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register in the block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_reg | input | 8 | Speed configuration value; bits [2:0] give the ratio code |
| ref_tick | input | 1 | One-cycle pulse per 14.318 MHz reference period |
| dbl_tick | input | 1 | One-cycle pulse per half PCLK2 period (double rate) |
| isa_clk | output | 1 | Generated ISA bus clock |
| isa_rise | output | 1 | One-cycle strobe in the cycle isa_clk rises |

## Verification
The half-integer codes are the most likely to go wrong. An off-by-one in the period lookup gives a 3-tick or 5-tick period the wrong high phase, or it turns the period into an even length. The directed phase-length measurements for codes 1, 3 and 7 would catch either fault. Random code changes every cycle check that the code is only adopted at the end of a period. A design that switched at once would shorten a phase or raise the clock early, so the cycle-by-cycle comparison with the bench model would fail. Sparse random ticks from both sources check that the inactive source is ignored and that the clock never moves without a tick. Random upper register bits would show any design that decodes more than three bits.

// File: rtl/isa_div_pkg.sv
package isa_div_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 4;

  typedef logic [SEL_W-1:0] code_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // ticks of the active source in one output period
  function automatic cnt_t period_of(code_t code);
    cnt_t p;
    case (code)
      3'd0: p = cnt_t'(2);
      3'd1: p = cnt_t'(3);
      3'd2: p = cnt_t'(4);
      3'd3: p = cnt_t'(5);
      3'd4: p = cnt_t'(6);
      3'd5: p = cnt_t'(8);
      3'd6: p = cnt_t'(10);
      default: p = cnt_t'(12);
    endcase
    return p;
  endfunction

  // ticks spent high: the larger half of the period
  function automatic cnt_t high_of(code_t code);
    logic [CNT_W:0] p1;
    p1 = {1'b0, period_of(code)} + 1'b1;
    return cnt_t'(p1 >> 1);
  endfunction

  // code 0 counts the reference; every other code counts the divider ticks
  function automatic logic uses_ref(code_t code);
    return (code == '0);
  endfunction
endpackage

// File: rtl/isa_src_mux.sv
module isa_src_mux
  import isa_div_pkg::*;
(
  input  code_t act_code,
  input  logic  ref_tick,
  input  logic  dbl_tick,
  output logic  tick_act
);
  // the source changes only together with act_code, i.e. at a period end
  always_comb begin
    if (uses_ref(act_code)) tick_act = ref_tick;
    else                    tick_act = dbl_tick;
  end
endmodule

// File: rtl/isa_period_ctr.sv
module isa_period_ctr
  import isa_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_act,
  input  code_t sel_code,
  output code_t act_code,
  output cnt_t  cnt,
  output logic  wrap,
  output code_t next_code,
  output cnt_t  next_cnt
);
  localparam code_t RST_CODE = '0;
  localparam cnt_t  RST_CNT  = period_of(RST_CODE) - cnt_t'(1);

  assign wrap      = tick_act && (cnt == period_of(act_code) - cnt_t'(1));
  assign next_code = wrap ? sel_code : act_code;
  assign next_cnt  = wrap ? '0 : cnt + cnt_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= RST_CODE;
      cnt      <= RST_CNT;
    end else if (tick_act) begin
      act_code <= next_code;
      cnt      <= next_cnt;
    end
  end
endmodule

// File: rtl/isa_phase_gen.sv
module isa_phase_gen
  import isa_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_act,
  input  logic  wrap,
  input  code_t next_code,
  input  cnt_t  next_cnt,
  output logic  isa_clk,
  output logic  isa_rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isa_clk  <= 1'b0;
      isa_rise <= 1'b0;
    end else begin
      isa_rise <= wrap;
      if (tick_act) isa_clk <= (next_cnt < high_of(next_code));
    end
  end
endmodule

// File: rtl/isa_clk_gen.sv
module isa_clk_gen
  import isa_div_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] speed_reg,
  input  logic             ref_tick,
  input  logic             dbl_tick,
  output logic             isa_clk,
  output logic             isa_rise
);
  code_t sel_code;
  code_t act_code;
  code_t next_code;
  cnt_t  cnt;
  cnt_t  next_cnt;
  logic  tick_act;
  logic  wrap;
  logic  unused_hi;

  assign sel_code  = speed_reg[SEL_W-1:0];
  assign unused_hi = ^speed_reg[REG_W-1:SEL_W];

  isa_src_mux u_mux (
    .act_code (act_code),
    .ref_tick (ref_tick),
    .dbl_tick (dbl_tick),
    .tick_act (tick_act)
  );

  isa_period_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_act  (tick_act),
    .sel_code  (sel_code),
    .act_code  (act_code),
    .cnt       (cnt),
    .wrap      (wrap),
    .next_code (next_code),
    .next_cnt  (next_cnt)
  );

  isa_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_act  (tick_act),
    .wrap      (wrap),
    .next_code (next_code),
    .next_cnt  (next_cnt),
    .isa_clk   (isa_clk),
    .isa_rise  (isa_rise)
  );
endmodule

// File: rtl/isa_clk_gen_chk.sv
module isa_clk_gen_chk
  import isa_div_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  tick_act,
  input logic  wrap,
  input code_t act_code,
  input cnt_t  cnt,
  input logic  isa_clk,
  input logic  isa_rise
);
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_code)); // R6
  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    isa_rise == $rose(isa_clk)); // R7
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    isa_rise |=> !isa_rise); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_act |=> $stable(isa_clk)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period_of(act_code)); // R3
  AST_WRAP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> isa_clk); // R4
endmodule

bind isa_clk_gen isa_clk_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_act (tick_act),
  .wrap     (wrap),
  .act_code (act_code),
  .cnt      (cnt),
  .isa_clk  (isa_clk),
  .isa_rise (isa_rise)
);

// File: tb/tb_isa_clk_gen.sv
module tb_isa_clk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] speed_reg = 8'h00;
  logic       ref_tick = 1'b0;
  logic       dbl_tick = 1'b0;
  logic       isa_clk;
  logic       isa_rise;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model: phase level, ticks left in phase, active code
  bit       m_phase;
  int       m_left;
  int       m_code;
  bit       m_rise;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_clk_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_reg (speed_reg),
    .ref_tick  (ref_tick),
    .dbl_tick  (dbl_tick),
    .isa_clk   (isa_clk),
    .isa_rise  (isa_rise)
  );

  function automatic int ticks_total(int code);
    return (code <= 4) ? code + 2 : 2 * code - 2;
  endfunction

  function automatic int ticks_high(int code);
    return ticks_total(code) - ticks_total(code) / 2;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_phase = 1'b0;
    m_left  = 1;
    m_code  = 0;
    m_rise  = 1'b0;
  endtask

  task automatic model_step(bit rt, bit dt, logic [7:0] s);
    bit act;
    act    = (m_code == 0) ? rt : dt;
    m_rise = 1'b0;
    if (act) begin
      m_left--;
      if (m_left == 0) begin
        if (m_phase) begin
          m_phase = 1'b0;
          m_left  = ticks_total(m_code) - ticks_high(m_code);
        end else begin
          m_code  = int'(s % 8);
          m_phase = 1'b1;
          m_left  = ticks_high(m_code);
          m_rise  = 1'b1;
        end
      end
    end
  endtask

  // drive one cycle from a negedge, check the outputs at the following negedge
  task automatic cycle(string tag, bit rt, bit dt, logic [7:0] s);
    ref_tick  = rt;
    dbl_tick  = dt;
    speed_reg = s;
    model_step(rt, dt, s);
    @(negedge clk);
    check(tag, int'(isa_clk), int'(m_phase), "isa_clk");
    check(tag, int'(isa_rise), int'(m_rise), "isa_rise");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_tick = 1'b0;
    dbl_tick = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R5", int'(isa_clk), 0, "isa_clk in reset");
    check("R5", int'(isa_rise), 0, "isa_rise in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // measure high and low lengths with ticks every cycle
  task automatic measure(logic [7:0] s, int code);
    int hi, lo, guard;
    for (int i = 0; i < 30; i++) cycle("R4", 1'b0, 1'b1, s);
    guard = 0;
    while (!isa_rise && guard < 40) begin
      cycle("R4", 1'b0, 1'b1, s);
      guard++;
    end
    hi = 0;
    while (isa_clk && hi < 40) begin
      hi++;
      cycle("R4", 1'b0, 1'b1, s);
    end
    lo = 0;
    while (!isa_clk && lo < 40) begin
      lo++;
      cycle("R4", 1'b0, 1'b1, s);
    end
    check("R4", hi, ticks_high(code), "high phase length");
    check("R4", lo, ticks_total(code) - ticks_high(code), "low phase length");
  endtask

  initial begin
    void'($urandom(32'h1e5eed));
    @(negedge clk);
    do_reset();

    // R5: first reference tick raises the clock; divider ticks do nothing first
    cycle("R5", 1'b0, 1'b1, 8'h00);
    check("R5", int'(isa_clk), 0, "isa_clk before ref tick");
    cycle("R5", 1'b1, 1'b0, 8'h00);
    check("R5", int'(isa_rise), 1, "first rise after reset");

    // R2: code 0, random ticks from both sources
    for (int i = 0; i < 400; i++)
      cycle("R2", 1'($urandom), 1'($urandom), 8'h00);

    // R3: each divider code held fixed
    for (int c = 1; c < 8; c++)
      for (int i = 0; i < 300; i++)
        cycle("R3", 1'($urandom), 1'($urandom % 4 != 0), 8'(c));

    // R4: directed phase lengths
    measure(8'h01, 1);
    measure(8'h03, 3);
    measure(8'h07, 7);

    // R1: random upper bits over a fixed low code
    for (int i = 0; i < 1500; i++)
      cycle("R1", 1'($urandom), 1'($urandom), {5'($urandom), 3'(i / 300 + 1)});

    // R6: code changes every cycle
    for (int i = 0; i < 4000; i++)
      cycle("R6", 1'($urandom), 1'($urandom), 8'($urandom));

    // R7 and R8: sparse ticks with occasional code changes
    for (int i = 0; i < 4000; i++)
      cycle((i % 2 == 0) ? "R7" : "R8", 1'($urandom % 5 == 0), 1'($urandom % 5 == 0),
            8'(($urandom % 16 == 0) ? $urandom : speed_reg));

    // reset in the middle of activity
    do_reset();
    for (int i = 0; i < 500; i++)
      cycle("R5", 1'($urandom), 1'($urandom), 8'($urandom));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule